// File: doc/BRIEF.md
# Indirect Jump Target Predictor with Return Ring

This block scores resolved control-transfer events against a prediction and keeps a jump-barrier cycle that a downstream scheduler must not schedule ahead of. Each event arrives with a one-cycle valid strobe. It carries a transfer kind, the byte address of the jump, the destination it actually reached, the return address for calls, and the cycle the instruction was scheduled into. Two structures predict targets. A circular ring holds return addresses and predicts returns. A last-destination table, indexed by jump address, predicts the other indirect transfers.

A mode input selects the scheme. The choices are perfect prediction, ring plus table, table only, or no prediction. On a misprediction the barrier moves up to the cycle of the offending jump, but it never moves down. The verdict and the updated barrier appear one clock after the event is accepted. The ring and table sizes are powers of two. The ring wraps without any sign when calls nest deeper than its size, and the oldest return addresses are overwritten.

Top module: `jmp_tgt_predictor`

## Requirements
- R1: After reset, `res_valid` and `res_miss` are 0, `barrier` is 0, and every ring entry, every table entry and the ring position read as zero. A destination of 0 is therefore predicted correctly by both structures.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `ev_valid` = 1. `res_miss` and `barrier` report that event in the same cycle.
- R3: Transfer kind encodings are 0 = indirect jump, 1 = direct call, 2 = return, 3 = indirect call. In mode 1, a call of kind 1 or 3 first moves the ring position forward by one, modulo `RING_DEPTH`, and then stores `ev_ret` at the new position.
- R4: Mode encodings are 0 = perfect, 1 = ring plus table, 2 = table only, 3 = none. In mode 1, a return compares the ring entry at the current position with `ev_dest`. On a match there is no miss and the position moves back by one, modulo `RING_DEPTH`. On a mismatch a miss is flagged and the ring is not changed.
- R5: In modes 1 and 2, kinds 0 and 3 look up the table entry `(ev_addr >> 2) mod TABLE_DEPTH`. In mode 2, returns do the same. The lookup misses when the stored destination differs from `ev_dest`. The entry is then overwritten with `ev_dest` whether the lookup hit or missed.
- R6: In mode 0 no event ever misses, and neither the ring nor the table changes.
- R7: In mode 3, every event of kind 0, 2 or 3 misses, and neither the ring nor the table changes.
- R8: On a miss, `barrier` becomes `ev_cycle` if `ev_cycle` is greater than the current barrier. Otherwise `barrier` keeps its value. `barrier` never changes without a miss.
- R9: When more than `RING_DEPTH` calls are pushed without returns, the ring wraps. The oldest entries are overwritten, and a later return to an overwritten address misses.
- R10: A direct call (kind 1) never misses in any mode. It pushes onto the ring only in mode 1 and never touches the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe, one event per cycle |
| ev_kind | input | 2 | Transfer kind (R3 encoding) |
| ev_addr | input | AW | Byte address of the transfer instruction |
| ev_dest | input | AW | Destination actually reached |
| ev_ret | input | AW | Return address pushed by calls |
| ev_cycle | input | CW | Cycle the instruction was scheduled into |
| mode | input | 2 | Prediction scheme (R4 encoding) |
| res_valid | output | 1 | Result strobe, one clock after `ev_valid` |
| res_miss | output | 1 | Misprediction verdict for the event |
| barrier | output | CW | Jump-barrier cycle |

## Verification
Random traffic draws addresses and destinations from small pools, so that table entries alias and repeat. This separates correct last-destination learning from stale or misindexed entries. Returns in ring mode are biased toward the true top of the ring, so that pops, mismatches that leave the ring intact, and pops after earlier mismatches all occur. Scheduled cycles mostly rise but sometimes fall back, which shows whether a miss only raises the barrier. Directed cases cover the zeroed state after reset, an overflow of the ring past its depth, two addresses sharing one table slot, and mode changes between pushes.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
   typedef enum logic [1:0] {
      XFER_JUMP  = 2'd0,
      XFER_CALL  = 2'd1,
      XFER_RET   = 2'd2,
      XFER_ICALL = 2'd3
   } xfer_kind_e;

   typedef enum logic [1:0] {
      PRED_PERFECT    = 2'd0,
      PRED_RING_TABLE = 2'd1,
      PRED_TABLE_ONLY = 2'd2,
      PRED_NONE       = 2'd3
   } pred_mode_e;
endpackage

// File: rtl/jtp_ring.sv
module jtp_ring #(
   parameter int AW    = 32,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_data,
   input  logic          pop,
   output logic [AW-1:0] top_data
);
   localparam int IW = $clog2(DEPTH);

   logic [IW-1:0] pos_q;
   logic [IW-1:0] pos_up;
   logic [IW-1:0] pos_dn;
   logic [AW-1:0] slot_q [DEPTH];
   logic [DEPTH-1:0] at_pos;

   // power-of-two depth: index arithmetic wraps by truncation
   assign pos_up = pos_q + IW'(1);
   assign pos_dn = pos_q - IW'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_sel
      assign at_pos[i] = (pos_q == IW'(i));
   end

   always_comb begin
      top_data = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (at_pos[j]) top_data = slot_q[j];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
         for (int j = 0; j < DEPTH; j++) slot_q[j] <= '0;
      end else if (push) begin
         pos_q         <= pos_up;
         slot_q[pos_up] <= push_data;
      end else if (pop) begin
         pos_q <= pos_dn;
      end
   end
endmodule

// File: rtl/jtp_table.sv
module jtp_table #(
   parameter int AW    = 32,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data
);
   logic [AW-1:0]    word_idx;
   logic [DEPTH-1:0] hit_sel;
   logic [AW-1:0]    ent_q [DEPTH];

   // byte address to word index, folded onto the table size
   assign word_idx = (addr >> 2) & AW'(DEPTH - 1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_dec
      assign hit_sel[i] = (word_idx == AW'(i));
   end

   always_comb begin
      rd_data = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (hit_sel[j]) rd_data = ent_q[j];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) ent_q[j] <= '0;
      end else if (wr_en) begin
         for (int j = 0; j < DEPTH; j++) begin
            if (hit_sel[j]) ent_q[j] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/jtp_decide.sv
module jtp_decide
   import jtp_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          ev_valid,
   input  logic [1:0]    ev_kind,
   input  logic [1:0]    mode,
   input  logic [AW-1:0] ev_dest,
   input  logic [AW-1:0] ring_top,
   input  logic [AW-1:0] tab_data,
   output logic          miss,
   output logic          ring_push,
   output logic          ring_pop,
   output logic          tab_wr
);
   xfer_kind_e kind;
   pred_mode_e md;
   logic ring_on, tab_on, is_call, ret_by_ring, by_table, ring_hit;

   assign kind        = xfer_kind_e'(ev_kind);
   assign md          = pred_mode_e'(mode);
   assign ring_on     = (md == PRED_RING_TABLE);
   assign tab_on      = (md == PRED_RING_TABLE) || (md == PRED_TABLE_ONLY);
   assign is_call     = (kind == XFER_CALL) || (kind == XFER_ICALL);
   assign ret_by_ring = (kind == XFER_RET) && ring_on;
   assign by_table    = tab_on && ((kind == XFER_JUMP) || (kind == XFER_ICALL) ||
                                   ((kind == XFER_RET) && !ring_on));
   assign ring_hit    = (ring_top == ev_dest);

   always_comb begin
      if (kind == XFER_CALL)      miss = 1'b0;
      else if (md == PRED_PERFECT) miss = 1'b0;
      else if (ret_by_ring)       miss = !ring_hit;
      else if (by_table)          miss = (tab_data != ev_dest);
      else                        miss = 1'b1;
   end

   assign ring_push = ev_valid && ring_on && is_call;
   assign ring_pop  = ev_valid && ret_by_ring && ring_hit;
   assign tab_wr    = ev_valid && by_table;
endmodule

// File: rtl/jtp_barrier.sv
module jtp_barrier #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          raise,
   input  logic [CW-1:0] cycle,
   output logic [CW-1:0] barrier
);
   logic [CW-1:0] bar_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                        bar_q <= '0;
      else if (raise && (cycle > bar_q)) bar_q <= cycle;
   end

   assign barrier = bar_q;
endmodule

// File: rtl/jmp_tgt_predictor.sv
module jmp_tgt_predictor #(
   parameter int AW          = 32,
   parameter int CW          = 32,
   parameter int RING_DEPTH  = 8,
   parameter int TABLE_DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_valid,
   input  logic [1:0]    ev_kind,
   input  logic [AW-1:0] ev_addr,
   input  logic [AW-1:0] ev_dest,
   input  logic [AW-1:0] ev_ret,
   input  logic [CW-1:0] ev_cycle,
   input  logic [1:0]    mode,
   output logic          res_valid,
   output logic          res_miss,
   output logic [CW-1:0] barrier
);
   localparam int TIW = $clog2(TABLE_DEPTH);

   initial begin
      assert (RING_DEPTH >= 2 && (RING_DEPTH & (RING_DEPTH - 1)) == 0)
         else $error("RING_DEPTH must be a power of two, at least 2");
      assert (TABLE_DEPTH >= 2 && (TABLE_DEPTH & (TABLE_DEPTH - 1)) == 0)
         else $error("TABLE_DEPTH must be a power of two, at least 2");
      assert (AW >= TIW + 2) else $error("AW too narrow for table index");
   end

   logic [AW-1:0] ring_top, tab_data;
   logic miss_c, push_c, pop_c, wr_c;
   logic valid_q, miss_q;

   jtp_ring #(.AW(AW), .DEPTH(RING_DEPTH)) u_ring (
      .clk(clk), .rst_n(rst_n), .push(push_c), .push_data(ev_ret),
      .pop(pop_c), .top_data(ring_top));

   jtp_table #(.AW(AW), .DEPTH(TABLE_DEPTH)) u_table (
      .clk(clk), .rst_n(rst_n), .addr(ev_addr), .rd_data(tab_data),
      .wr_en(wr_c), .wr_data(ev_dest));

   jtp_decide #(.AW(AW)) u_decide (
      .ev_valid(ev_valid), .ev_kind(ev_kind), .mode(mode), .ev_dest(ev_dest),
      .ring_top(ring_top), .tab_data(tab_data), .miss(miss_c),
      .ring_push(push_c), .ring_pop(pop_c), .tab_wr(wr_c));

   jtp_barrier #(.CW(CW)) u_barrier (
      .clk(clk), .rst_n(rst_n), .raise(ev_valid && miss_c),
      .cycle(ev_cycle), .barrier(barrier));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         miss_q  <= 1'b0;
      end else begin
         valid_q <= ev_valid;
         miss_q  <= ev_valid && miss_c;
      end
   end

   assign res_valid = valid_q;
   assign res_miss  = miss_q;
endmodule

// File: rtl/jtp_checker.sv
module jtp_checker #(
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ev_valid,
   input logic [1:0]    ev_kind,
   input logic [1:0]    mode,
   input logic [CW-1:0] ev_cycle,
   input logic          res_valid,
   input logic          res_miss,
   input logic [CW-1:0] barrier
);
   AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> res_valid);  // R2
   AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> (!res_valid && !res_miss));  // R2
   AST_PERFECT_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && mode == 2'd0) |=> !res_miss);  // R6
   AST_NONE_ALWAYS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && mode == 2'd3 && ev_kind != 2'd1) |=> res_miss);  // R7
   AST_DIRECT_CALL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == 2'd1) |=> !res_miss);  // R10
   AST_BARRIER_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> barrier >= $past(barrier));  // R8
   AST_BARRIER_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> $stable(barrier));  // R8
   AST_BARRIER_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> (res_miss ? (barrier >= $past(ev_cycle))
                             : (barrier == $past(barrier))));  // R8
endmodule

bind jmp_tgt_predictor jtp_checker #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
   .mode(mode), .ev_cycle(ev_cycle), .res_valid(res_valid),
   .res_miss(res_miss), .barrier(barrier));

// File: tb/tb_jmp_tgt_predictor.sv
module tb_jmp_tgt_predictor;
   localparam int AW = 32;
   localparam int CW = 32;
   localparam int RD = 8;
   localparam int TD = 16;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_valid = 1'b0;
   logic [1:0] ev_kind = '0;
   logic [AW-1:0] ev_addr = '0, ev_dest = '0, ev_ret = '0;
   logic [CW-1:0] ev_cycle = '0;
   logic [1:0] mode = '0;
   logic res_valid, res_miss;
   logic [CW-1:0] barrier;

   jmp_tgt_predictor #(.AW(AW), .CW(CW), .RING_DEPTH(RD), .TABLE_DEPTH(TD)) dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_addr(ev_addr), .ev_dest(ev_dest), .ev_ret(ev_ret), .ev_cycle(ev_cycle),
      .mode(mode), .res_valid(res_valid), .res_miss(res_miss), .barrier(barrier));

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int n_cyc = 0;

   // bench reference state
   logic [AW-1:0] m_ring [RD];
   int            m_pos;
   logic [AW-1:0] m_tab [TD];
   logic [CW-1:0] m_bar;

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc >= WATCHDOG) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog actual=%0d expected<%0d cycles", n_cyc, WATCHDOG);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [1:0] k, input logic [1:0] md);
      if (k == 2'd1) return "R10";
      if (md == 2'd0) return "R6";
      if (md == 2'd3) return "R7";
      if (k == 2'd2 && md == 2'd1) return "R4";
      return "R5";
   endfunction

   task automatic model_step(input logic [1:0] k, input logic [AW-1:0] a,
                             input logic [AW-1:0] d, input logic [AW-1:0] r,
                             input logic [CW-1:0] c, input logic [1:0] md,
                             output logic em);
      bit ring_on = (md == 2'd1);
      bit tab_on  = (md == 2'd1) || (md == 2'd2);
      int ti = int'((a >> 2) % TD);
      if ((k == 2'd1 || k == 2'd3) && ring_on) begin
         m_pos = (m_pos + 1) % RD;
         m_ring[m_pos] = r;
      end
      if (k == 2'd1) em = 1'b0;
      else if (md == 2'd0) em = 1'b0;
      else if (k == 2'd2 && ring_on) begin
         em = (m_ring[m_pos] != d);
         if (!em) m_pos = (m_pos + RD - 1) % RD;
      end else if (tab_on) begin
         em = (m_tab[ti] != d);
         m_tab[ti] = d;
      end else em = 1'b1;
      if (em && c > m_bar) m_bar = c;
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic send(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [AW-1:0] d, input logic [AW-1:0] r,
                       input logic [CW-1:0] c, input logic [1:0] md, input string tag);
      logic em;
      model_step(k, a, d, r, c, md, em);
      ev_valid = 1'b1; ev_kind = k; ev_addr = a; ev_dest = d; ev_ret = r;
      ev_cycle = c; mode = md;
      @(negedge clk);
      ev_valid = 1'b0;
      chk({"R2 valid ", tag}, CW'(res_valid), CW'(1));
      chk({tag, " miss"}, CW'(res_miss), CW'(em));
      chk("R8 barrier", barrier, m_bar);
   endtask

   logic [AW-1:0] pool [4];

   initial begin
      logic [CW-1:0] cur;
      void'($urandom(32'd4242));
      pool[0] = 32'h1000; pool[1] = 32'h2000; pool[2] = 32'h3000; pool[3] = 32'h4000;
      for (int i = 0; i < RD; i++) m_ring[i] = '0;
      for (int i = 0; i < TD; i++) m_tab[i] = '0;
      m_pos = 0;
      m_bar = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 res_valid", CW'(res_valid), CW'(0));
      chk("R1 res_miss", CW'(res_miss), CW'(0));
      chk("R1 barrier", barrier, '0);
      send(2'd0, 32'h40, 32'h0, 32'h0, 32'd5, 2'd2, "R1 table zero");
      send(2'd2, 32'h80, 32'h0, 32'h0, 32'd6, 2'd1, "R1 ring zero");

      // R2: idle cycle gives no result
      @(negedge clk);
      chk("R2 idle valid", CW'(res_valid), CW'(0));

      // R3/R4: push then matching return, then mismatching return
      send(2'd1, 32'h100, 32'h900, 32'h104, 32'd10, 2'd1, "R3 push");
      send(2'd2, 32'h200, 32'h104, 32'h0, 32'd11, 2'd1, "R3 pop hit");
      send(2'd1, 32'h100, 32'h900, 32'h108, 32'd12, 2'd1, "R3 push2");
      send(2'd2, 32'h200, 32'h10c, 32'h0, 32'd20, 2'd1, "R4 mismatch");
      send(2'd2, 32'h200, 32'h108, 32'h0, 32'd21, 2'd1, "R4 ring kept");

      // R10: direct call in table mode neither misses nor pushes
      send(2'd1, 32'h100, 32'h900, 32'h777, 32'd22, 2'd2, "R10 no push");
      send(2'd2, 32'h204, 32'h777, 32'h0, 32'd23, 2'd1, "R10 ring unchanged");

      // R5: aliasing table slot (0x10 and 0x50 share index 4)
      send(2'd0, 32'h10, 32'hA00, 32'h0, 32'd30, 2'd2, "R5 learn");
      send(2'd0, 32'h10, 32'hA00, 32'h0, 32'd31, 2'd2, "R5 hit");
      send(2'd0, 32'h50, 32'hB00, 32'h0, 32'd32, 2'd2, "R5 alias miss");
      send(2'd0, 32'h10, 32'hA00, 32'h0, 32'd33, 2'd1, "R5 alias evicted");

      // R8: a miss at an earlier cycle keeps the barrier
      send(2'd0, 32'h20, 32'hC00, 32'h0, 32'd15, 2'd3, "R8 lower cycle");
      send(2'd0, 32'h20, 32'hC00, 32'h0, 32'd50, 2'd3, "R8 higher cycle");

      // R6: perfect mode changes no state
      send(2'd0, 32'h10, 32'hDDD, 32'h0, 32'd60, 2'd0, "R6 perfect");
      send(2'd0, 32'h10, 32'hA00, 32'h0, 32'd61, 2'd2, "R6 table untouched");

      // R9: ring overflow
      for (int i = 0; i < RD + 2; i++)
         send(2'd1, 32'h300, 32'h0, 32'h500 + AW'(i * 4), 32'd70, 2'd1, "R9 push");
      for (int i = RD + 1; i >= 2; i--)
         send(2'd2, 32'h304, 32'h500 + AW'(i * 4), 32'h0, 32'd71, 2'd1, "R9 pop");
      send(2'd2, 32'h304, 32'h504, 32'h0, 32'd80, 2'd1, "R9 overwritten");

      // random traffic
      cur = 32'd100;
      for (int n = 0; n < 800; n++) begin
         logic [1:0] k, md;
         logic [AW-1:0] a, d, r;
         logic [CW-1:0] c;
         k  = 2'($urandom % 4);
         md = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'd1;
         a  = AW'(($urandom % 24) << 2);
         d  = pool[$urandom % 4];
         r  = pool[$urandom % 4] + AW'(4);
         if (k == 2'd2 && md == 2'd1 && ($urandom % 10 < 6)) d = m_ring[m_pos];
         cur = cur + CW'($urandom % 5);
         c = ($urandom % 3 == 0) ? cur - CW'($urandom % 8) : cur;
         send(k, a, d, r, c, md, tag_of(k, md));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule